// File: doc/BRIEF.md
# Control-Transfer Program Counter Unit

This block holds the program counter of a 16-bit teaching processor and works out its next value. Each fetched instruction arrives on a valid/ready stream together with the address it came from, which is the current PC. The unit decodes three kinds of control transfer and sends every other instruction sequentially to PC+1. The three kinds are a conditional branch on the stored negative/zero/positive flags, an unconditional jump through a base register, and a trap that enters a service routine through a vector table held in data memory.

The unit has a combinational read port into the register file, used for the jump base register. It has a write port into the same file, which stores the return address on a trap. It also drives a data-memory read port with one cycle of latency, which fetches the trap vector. A trap stalls the instruction stream for one cycle while the vector word comes back. Back-pressure rules: an instruction is consumed only in a cycle where `instr_valid` and `instr_ready` are both high. While `instr_ready` is low, the producer must hold the instruction and its valid. While `instr_valid` is low, the PC does not move. The unit only reads the condition flags and never changes them.

Top module: `pc_ctrl_unit`

## Requirements
- R1: After a synchronous reset, `pc` equals RESET_PC (default 16'h3000), `instr_ready` is 1, and `rf_we` and `mem_req` are 0.
- R2: An accepted instruction whose opcode (bits [15:12]) is not 4'b0000, 4'b1100 or 4'b1111 sets `pc` to `pc`+1 on the accepting edge.
- R3: A branch has opcode 4'b0000, a mask in bits [11:9] ordered n,z,p from bit 11 down, and a two's-complement offset in bits [8:0]. If the mask AND `cond_nzp` is nonzero, `pc` becomes `pc`+1 plus the sign-extended offset. Negative offsets move backwards.
- R4: A branch whose mask AND `cond_nzp` is zero sets `pc` to `pc`+1. A mask of 3'b000 never branches.
- R5: A branch with mask 3'b111 is taken for every one-hot `cond_nzp`.
- R6: A jump is opcode 4'b1100 with bits [11:9]=0 and bits [5:0]=0. While it is presented, `rf_raddr` equals bits [8:6], and on acceptance `pc` becomes `rf_rdata`.
- R7: A trap is opcode 4'b1111 with bits [11:8]=0. In its accepting cycle `rf_we`=1, `rf_waddr`=7, `rf_wdata`=`pc`+1, `mem_req`=1 and `mem_addr` is bits [7:0] zero-extended. No other cycle asserts `rf_we` or `mem_req`.
- R8: After a trap is accepted, `instr_ready` is 0 for exactly one cycle. At the end of that cycle `pc` loads `mem_rdata`, and `instr_ready` returns to 1.
- R9: `pc` holds while no instruction is accepted. An instruction held valid during the trap stall is consumed only after the stall ends.
- R10: An opcode 4'b1100 or 4'b1111 word whose reserved bits are not zero behaves as a sequential instruction: no register write and no memory request.
- R11: All PC arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | Instruction word present |
| instr_ready | output | 1 | Unit can accept an instruction |
| instr | input | 16 | Instruction fetched from address `pc` |
| cond_nzp | input | 3 | Stored condition flags {n,z,p} |
| rf_raddr | output | 3 | Register-file read index (base register) |
| rf_rdata | input | 16 | Register-file read data, combinational |
| rf_we | output | 1 | Register-file write enable (return link) |
| rf_waddr | output | 3 | Register-file write index |
| rf_wdata | output | 16 | Register-file write data |
| mem_req | output | 1 | Data-memory read request |
| mem_addr | output | 16 | Data-memory read address |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_req` |
| pc | output | 16 | Current program counter |

## Verification
The branch decision is tried with several patterns. A single mask bit matching the flag shows the AND test is taken. A single bit against a different flag shows fall-through. An all-zero mask with a flag set shows that it never branches. An all-ones mask with a negative offset exercises both the catch-all mask and sign extension. Jumps and traps are each given a well-formed word and a word with one reserved bit set; the second word separates a true field decode from an opcode-only decode. A trap followed immediately by a held instruction shows the stall ordering. A jump to the top of the address space, followed by an increment and a forward branch, exercises the wrap-around.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [1:0] {
    XK_SEQ  = 2'd0,
    XK_BR   = 2'd1,
    XK_JMP  = 2'd2,
    XK_TRAP = 2'd3
  } xfer_kind_e;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_VECW = 1'b1
  } pcu_state_e;

  localparam logic [3:0] OPC_BR   = 4'b0000;
  localparam logic [3:0] OPC_JMP  = 4'b1100;
  localparam logic [3:0] OPC_TRAP = 4'b1111;
endpackage

// File: rtl/pcu_decode.sv
module pcu_decode
  import pcu_pkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int RIDX_W  = 3,
  parameter int OFF_W   = 9,
  parameter int VEC_W   = 8
) (
  input  logic [INSTR_W-1:0] word,
  output xfer_kind_e         kind,
  output logic [RIDX_W-1:0]  mask,
  output logic [OFF_W-1:0]   offset,
  output logic [RIDX_W-1:0]  base_idx,
  output logic [VEC_W-1:0]   vector
);
  localparam int OPC_LSB = INSTR_W - 4;

  logic [3:0] opc;
  logic       jmp_clean;
  logic       trap_clean;

  assign opc      = word[INSTR_W-1:OPC_LSB];
  assign mask     = word[OPC_LSB-1:OPC_LSB-RIDX_W];
  assign offset   = word[OFF_W-1:0];
  assign base_idx = word[OPC_LSB-RIDX_W-1:OPC_LSB-2*RIDX_W];
  assign vector   = word[VEC_W-1:0];

  assign jmp_clean  = (mask == '0) && (word[OPC_LSB-2*RIDX_W-1:0] == '0);
  assign trap_clean = (word[OPC_LSB-1:VEC_W] == '0);

  always_comb begin
    kind = XK_SEQ;
    unique case (opc)
      OPC_BR:   kind = XK_BR;
      OPC_JMP:  kind = jmp_clean  ? XK_JMP  : XK_SEQ;
      OPC_TRAP: kind = trap_clean ? XK_TRAP : XK_SEQ;
      default:  kind = XK_SEQ;
    endcase
  end
endmodule

// File: rtl/pcu_cond.sv
module pcu_cond #(
  parameter int FLAG_W = 3
) (
  input  logic [FLAG_W-1:0] mask,
  input  logic [FLAG_W-1:0] flags,
  output logic              take
);
  logic [FLAG_W-1:0] hit;

  for (genvar i = 0; i < FLAG_W; i++) begin : g_hit
    assign hit[i] = mask[i] & flags[i];
  end

  assign take = |hit;
endmodule

// File: rtl/pcu_target.sv
module pcu_target #(
  parameter int PC_W  = 16,
  parameter int OFF_W = 9
) (
  input  logic [PC_W-1:0]  cur_pc,
  input  logic [OFF_W-1:0] offset,
  output logic [PC_W-1:0]  seq_pc,
  output logic [PC_W-1:0]  br_pc
);
  localparam int EXT_W = PC_W - OFF_W;

  logic [PC_W-1:0] off_ext;

  assign off_ext = {{EXT_W{offset[OFF_W-1]}}, offset};
  assign seq_pc  = cur_pc + PC_W'(1);
  assign br_pc   = seq_pc + off_ext;
endmodule

// File: rtl/pc_ctrl_unit.sv
module pc_ctrl_unit
  import pcu_pkg::*;
#(
  parameter int          PC_W     = 16,
  parameter int          RIDX_W   = 3,
  parameter int          OFF_W    = 9,
  parameter int          VEC_W    = 8,
  parameter logic [15:0] RESET_PC = 16'h3000,
  parameter int          LINK_REG = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  output logic              instr_ready,
  input  logic [PC_W-1:0]   instr,
  input  logic [RIDX_W-1:0] cond_nzp,
  output logic [RIDX_W-1:0] rf_raddr,
  input  logic [PC_W-1:0]   rf_rdata,
  output logic              rf_we,
  output logic [RIDX_W-1:0] rf_waddr,
  output logic [PC_W-1:0]   rf_wdata,
  output logic              mem_req,
  output logic [PC_W-1:0]   mem_addr,
  input  logic [PC_W-1:0]   mem_rdata,
  output logic [PC_W-1:0]   pc
);
  localparam int VEC_PAD = PC_W - VEC_W;

  xfer_kind_e        kind;
  pcu_state_e        state;
  logic [RIDX_W-1:0] br_mask;
  logic [OFF_W-1:0]  br_off;
  logic [RIDX_W-1:0] base_idx;
  logic [VEC_W-1:0]  vec;
  logic              br_take;
  logic [PC_W-1:0]   seq_pc;
  logic [PC_W-1:0]   br_pc;
  logic              fire;
  logic              trap_fire;

  pcu_decode #(
    .INSTR_W(PC_W), .RIDX_W(RIDX_W), .OFF_W(OFF_W), .VEC_W(VEC_W)
  ) u_dec (
    .word(instr), .kind(kind), .mask(br_mask), .offset(br_off),
    .base_idx(base_idx), .vector(vec)
  );

  pcu_cond #(.FLAG_W(RIDX_W)) u_cond (
    .mask(br_mask), .flags(cond_nzp), .take(br_take)
  );

  pcu_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_tgt (
    .cur_pc(pc), .offset(br_off), .seq_pc(seq_pc), .br_pc(br_pc)
  );

  assign instr_ready = (state == ST_RUN);
  assign fire        = instr_valid && instr_ready;
  assign trap_fire   = fire && (kind == XK_TRAP);

  assign rf_raddr = base_idx;
  assign rf_we    = trap_fire;
  assign rf_waddr = RIDX_W'(LINK_REG);
  assign rf_wdata = seq_pc;
  assign mem_req  = trap_fire;
  assign mem_addr = {{VEC_PAD{1'b0}}, vec};

  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= PC_W'(RESET_PC);
      state <= ST_RUN;
    end else begin
      unique case (state)
        ST_RUN: begin
          if (fire) begin
            unique case (kind)
              XK_BR:   pc <= br_take ? br_pc : seq_pc;
              XK_JMP:  pc <= rf_rdata;
              XK_TRAP: state <= ST_VECW;
              default: pc <= seq_pc;
            endcase
          end
        end
        ST_VECW: begin
          pc    <= mem_rdata;
          state <= ST_RUN;
        end
        default: state <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
  parameter int PC_W   = 16,
  parameter int RIDX_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              instr_valid,
  input logic              instr_ready,
  input logic [PC_W-1:0]   instr,
  input logic              rf_we,
  input logic [RIDX_W-1:0] rf_waddr,
  input logic              mem_req,
  input logic [PC_W-1:0]   mem_rdata,
  input logic [PC_W-1:0]   pc
);
  logic seq_op;
  assign seq_op = (instr[15:12] != 4'b0000) && (instr[15:12] != 4'b1100) &&
                  (instr[15:12] != 4'b1111);

  a_r2_seq_step: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && instr_ready && seq_op) |=> (pc == $past(pc) + PC_W'(1)));

  a_r7_link_reg: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> (rf_waddr == RIDX_W'(7)) && mem_req && instr_valid && instr_ready);

  a_r8_one_stall: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !instr_ready);

  a_r8_vector_load: assert property (@(posedge clk) disable iff (rst)
    !instr_ready |=> instr_ready && (pc == $past(mem_rdata)));

  a_r9_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (instr_ready && !instr_valid) |=> $stable(pc));
endmodule

bind pc_ctrl_unit pcu_checker #(.PC_W(PC_W), .RIDX_W(RIDX_W)) u_pcu_chk (
  .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_ready(instr_ready),
  .instr(instr), .rf_we(rf_we), .rf_waddr(rf_waddr), .mem_req(mem_req),
  .mem_rdata(mem_rdata), .pc(pc)
);

// File: tb/tb_pc_ctrl_unit.sv
`timescale 1ns/1ps
module tb_pc_ctrl_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        instr_valid;
  logic        instr_ready;
  logic [15:0] instr;
  logic [2:0]  cond_nzp;
  logic [2:0]  rf_raddr;
  logic [15:0] rf_rdata;
  logic        rf_we;
  logic [2:0]  rf_waddr;
  logic [15:0] rf_wdata;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic [15:0] mem_rdata;
  logic [15:0] pc;

  int checks = 0;
  int fails  = 0;
  logic [15:0] exp_pc;
  logic [15:0] regs [8];

  always #4 clk = ~clk;

  pc_ctrl_unit dut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr(instr), .cond_nzp(cond_nzp), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .pc(pc)
  );

  function automatic logic [15:0] vec_word(input logic [15:0] a);
    return 16'h4000 + a * 16'd5;
  endfunction

  assign rf_rdata = regs[rf_raddr];

  always_ff @(posedge clk)
    if (mem_req) mem_rdata <= vec_word(mem_addr);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic present(input logic [15:0] w);
    @(negedge clk);
    instr       = w;
    instr_valid = 1'b1;
    #1;
  endtask

  task automatic after_edge();
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 pc", pc, 16'h3000);
    chk("R1 ready", {15'd0, instr_ready}, 16'd1);
    chk("R1 idle ports", {14'd0, rf_we, mem_req}, 16'd0);
    exp_pc = 16'h3000;
  endtask

  task automatic t_seq(input logic [15:0] w, input string req);
    present(w);
    chk({req, " no write"}, {14'd0, rf_we, mem_req}, 16'd0);
    after_edge();
    exp_pc = exp_pc + 16'd1;
    chk(req, pc, exp_pc);
  endtask

  task automatic t_idle();
    @(negedge clk);
    instr_valid = 1'b0;
    @(negedge clk);
    chk("R9 idle hold", pc, exp_pc);
  endtask

  task automatic t_br(input logic [2:0] m, input logic [8:0] off, input logic [2:0] cc,
                      input string req);
    cond_nzp = cc;
    present({4'b0000, m, off});
    after_edge();
    if ((m & cc) != 3'b000)
      exp_pc = exp_pc + 16'd1 + {{7{off[8]}}, off};
    else
      exp_pc = exp_pc + 16'd1;
    chk(req, pc, exp_pc);
  endtask

  task automatic t_jmp(input logic [2:0] b);
    present({4'b1100, 3'b000, b, 6'b000000});
    chk("R6 raddr", {13'd0, rf_raddr}, {13'd0, b});
    after_edge();
    exp_pc = regs[b];
    chk("R6 jump target", pc, exp_pc);
  endtask

  task automatic t_trap(input logic [7:0] v);
    logic [15:0] link;
    link = exp_pc + 16'd1;
    present({4'b1111, 4'b0000, v});
    chk("R7 we", {15'd0, rf_we}, 16'd1);
    chk("R7 waddr", {13'd0, rf_waddr}, 16'd7);
    chk("R7 link", rf_wdata, link);
    chk("R7 mem_req", {15'd0, mem_req}, 16'd1);
    chk("R7 mem_addr", mem_addr, {8'h00, v});
    @(negedge clk);
    instr = 16'h5AAA;
    chk("R8 stall", {15'd0, instr_ready}, 16'd0);
    chk("R9 pc held in stall", pc, exp_pc);
    chk("R7 no second write", {14'd0, rf_we, mem_req}, 16'd0);
    @(negedge clk);
    exp_pc = vec_word({8'h00, v});
    chk("R8 vector pc", pc, exp_pc);
    chk("R8 ready back", {15'd0, instr_ready}, 16'd1);
    after_edge();
    exp_pc = exp_pc + 16'd1;
    chk("R9 held instr consumed after stall", pc, exp_pc);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) regs[i] = 16'h1000 * i[15:0] + 16'h0011;
    regs[2] = 16'h5000;
    regs[5] = 16'hFFFF;
    regs[6] = 16'hFFFE;
    rst = 1'b1; instr_valid = 1'b0; instr = 16'h0; cond_nzp = 3'b010;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_seq(16'h1234, "R2 add step");
    t_idle();
    t_br(3'b010, 9'd5, 3'b010, "R3 taken z");
    t_br(3'b100, 9'd5, 3'b010, "R4 not taken");
    t_br(3'b000, 9'd16, 3'b001, "R4 mask zero");
    t_br(3'b111, 9'h1FD, 3'b100, "R5 all mask negative offset R3");
    t_br(3'b111, 9'd2, 3'b001, "R5 all mask p");
    t_jmp(3'd2);
    t_seq(16'hC081, "R10 bad jmp");
    t_trap(8'h25);
    t_seq(16'hF125, "R10 bad trap");
    t_jmp(3'd5);
    t_seq(16'h9FFF, "R11 wrap inc");
    t_jmp(3'd6);
    t_br(3'b001, 9'd3, 3'b001, "R11 branch wrap");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule